// File: doc/BRIEF.md
# Cascaded ISA Interrupt Router

This block takes sixteen level-sensitive interrupt request lines, arranged as a primary group (lines 0 to 7) and a secondary group (lines 8 to 15), and reduces them to two interrupt levels for a processor. Each group holds a request register and a mask register. A bit is pending when its request is set and its mask is clear. Any pending secondary bit is folded into bit 2 of the primary request register, so the secondary group reaches the processor through that one primary position.

The primary pending vector is divided by an 8-bit selection register. Pending bits that fall inside the selection drive the `irq_local` output. Pending bits outside it drive `irq_isa`. Both outputs are registered, and they are refreshed only on a cycle in which the primary pending vector changes.

Line events arrive one per clock as a valid strobe, a 5-bit line number and a set/clear flag. A line number of 16 or higher touches no request bit and only re-runs the fold. A separate count of pending timer interrupts goes up on a tick input. It goes down when primary request bit 0 falls.

Top module: `isa_irq_router`

## Requirements
- R1: An accepted event on line L in 0..7 sets (`ev_set`=1) or clears (`ev_set`=0) bit L of the primary request register. For L in 8..15 it sets or clears bit L-8 of the secondary request register. The change takes effect at the next clock edge.
- R2: A primary line whose mask bit is 1 does not make either output assert. A primary mask bit written back to 0 while its request is still set makes the line count again.
- R3: Primary request bit 2 always equals the OR of the secondary pending bits (secondary request AND NOT secondary mask). Events on line 2 therefore have no lasting effect on it.
- R4: After a refresh, `irq_local` = OR(primary pending AND selection) and `irq_isa` = OR(primary pending AND NOT selection). The outputs change one clock after the event that caused the refresh.
- R5: The outputs are refreshed only when the primary pending vector changes. A write to the selection register alone leaves both outputs as they were, and the new selection applies at the next refresh.
- R6: On synchronous reset, all request and mask registers clear, both outputs go low, the timer count goes to 0 and the selection register goes to 0x18. Lines 3 and 4 then drive `irq_local`, and every other primary bit drives `irq_isa`.
- R7: `tmr_tick` raises the timer count by one and holds it at its maximum. A fall of primary request bit 0 lowers it by one unless it is already 0. A tick and a fall in the same cycle leave the count unchanged.
- R8: An event with line number 16..31 changes no request bit. That holds for the bit equal to the line number mod 8 as well.
- R9: Mask writes (`pri_mask_we`, `sec_mask_we` with `mask_wdata`) take effect at the next clock. The secondary fold and the output refresh are evaluated against the new mask in that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Line event strobe, one event per cycle |
| ev_line | input | 5 | Line number of the event (0..15 real, 16..31 re-evaluate only) |
| ev_set | input | 1 | 1 = line asserted, 0 = line deasserted |
| pri_mask_we | input | 1 | Write `mask_wdata` into the primary mask register |
| sec_mask_we | input | 1 | Write `mask_wdata` into the secondary mask register |
| mask_wdata | input | 8 | Mask write data, 1 = bit masked |
| sel_we | input | 1 | Write `sel_wdata` into the selection register |
| sel_wdata | input | 8 | Selection data, 1 = bit routed to `irq_local` |
| tmr_tick | input | 1 | One pending timer interrupt added |
| irq_local | output | 1 | Level for selected primary pending bits |
| irq_isa | output | 1 | Level for unselected primary pending bits |
| tmr_pending | output | CNT_W | Pending timer interrupt count |

## Verification
The bench targets the fold at bit 2. It sets and clears primary line 2 while a secondary line is pending and while none is; a design that let line 2 write that bit would raise or drop `irq_isa` wrongly. It writes the selection register on its own and then fires line 16, and expects the outputs to stay stale until the pending vector really moves; a design that refreshed every cycle would flip `irq_local` early. It clears line 22, which a design that decoded only the low three bits would take as a clear of line 6. On the counter side it checks a tick and a fall in the same cycle, saturation at 255, a repeated clear of an already-clear line 0, and a fall with the count at 0; a wrong design would drift, wrap or underflow.

// File: rtl/isa_irq_pkg.sv
package isa_irq_pkg;
    localparam int GRP_W    = 8;
    localparam int LINE_W   = 5;
    localparam int IDX_W    = $clog2(GRP_W);
    localparam int FOLD_BIT = 2;
    localparam logic [GRP_W-1:0] SEL_DEFAULT = 8'h18;

    // Where one line event lands.
    typedef struct packed {
        logic             to_pri;
        logic             to_sec;
        logic [IDX_W-1:0] idx;
    } line_route_t;

    // The two processor-facing levels.
    typedef struct packed {
        logic local_lvl;
        logic isa_lvl;
    } irq_pair_t;

    function automatic line_route_t route_line(input logic valid,
                                               input logic [LINE_W-1:0] line);
        line_route_t r;
        r.idx    = line[IDX_W-1:0];
        r.to_pri = valid && (line[LINE_W-1:IDX_W] == 2'd0);
        r.to_sec = valid && (line[LINE_W-1:IDX_W] == 2'd1);
        return r;
    endfunction

    function automatic irq_pair_t split_pending(input logic [GRP_W-1:0] pend,
                                                input logic [GRP_W-1:0] sel);
        irq_pair_t p;
        p.local_lvl = |(pend & sel);
        p.isa_lvl   = |(pend & ~sel);
        return p;
    endfunction
endpackage

// File: rtl/isa_irq_bank.sv
module isa_irq_bank
    import isa_irq_pkg::*;
#(
    parameter bit FOLD_EN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_hit,
    input  logic             ev_set,
    input  logic [IDX_W-1:0] ev_idx,
    input  logic             fold_in,
    input  logic             mask_we,
    input  logic [GRP_W-1:0] mask_wd,
    output logic [GRP_W-1:0] req_q,
    output logic [GRP_W-1:0] pend_q,
    output logic [GRP_W-1:0] pend_nxt
);
    logic [GRP_W-1:0] mask_q;
    logic [GRP_W-1:0] req_nxt;
    logic [GRP_W-1:0] mask_nxt;

    always_comb begin
        req_nxt = req_q;
        if (ev_hit) req_nxt[ev_idx] = ev_set;
        if (FOLD_EN) req_nxt[FOLD_BIT] = fold_in;
        mask_nxt = mask_we ? mask_wd : mask_q;
        pend_nxt = req_nxt & ~mask_nxt;
    end

    assign pend_q = req_q & ~mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            mask_q <= '0;
        end else begin
            req_q  <= req_nxt;
            mask_q <= mask_nxt;
        end
    end

    // R1: an accepted set or clear lands on the addressed bit.
    assert_line_set_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_hit && ev_set && !(FOLD_EN && ev_idx == IDX_W'(FOLD_BIT)))
        |=> req_q[$past(ev_idx)]);
    assert_line_clr_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_hit && !ev_set && !(FOLD_EN && ev_idx == IDX_W'(FOLD_BIT)))
        |=> !req_q[$past(ev_idx)]);
endmodule

// File: rtl/isa_irq_split.sv
module isa_irq_split
    import isa_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [GRP_W-1:0] pend_q,
    input  logic [GRP_W-1:0] pend_nxt,
    input  logic [GRP_W-1:0] sel_q,
    output logic             irq_local,
    output logic             irq_isa
);
    irq_pair_t lvl_q;
    logic      chg;

    assign chg = (pend_nxt != pend_q);

    always_ff @(posedge clk) begin
        if (rst)      lvl_q <= '0;
        else if (chg) lvl_q <= split_pending(pend_nxt, sel_q);
    end

    assign irq_local = lvl_q.local_lvl;
    assign irq_isa   = lvl_q.isa_lvl;

    // R5: levels only move on an edge where the pending vector moved.
    assert_hold_unless_change_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(chg)) |-> ($stable(irq_local) && $stable(irq_isa)));
endmodule

// File: rtl/isa_irq_tmr_cnt.sv
module isa_irq_tmr_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fall,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick && !fall) begin
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else if (fall && !tick) begin
            if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    // R7: a lone fall takes one off a nonzero count and never wraps below 0.
    assert_dec_R7: assert property (@(posedge clk) disable iff (rst)
        (fall && !tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
    assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
        (fall && !tick && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/isa_irq_router.sv
module isa_irq_router
    import isa_irq_pkg::*;
#(
    parameter int              CNT_W    = 8,
    parameter logic [GRP_W-1:0] SEL_INIT = SEL_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [LINE_W-1:0] ev_line,
    input  logic              ev_set,
    input  logic              pri_mask_we,
    input  logic              sec_mask_we,
    input  logic [GRP_W-1:0]  mask_wdata,
    input  logic              sel_we,
    input  logic [GRP_W-1:0]  sel_wdata,
    input  logic              tmr_tick,
    output logic              irq_local,
    output logic              irq_isa,
    output logic [CNT_W-1:0]  tmr_pending
);
    line_route_t      rt;
    logic [GRP_W-1:0] pri_req_q, pri_pend_q, pri_pend_nxt;
    logic [GRP_W-1:0] sec_req_q, sec_pend_q, sec_pend_nxt;
    logic [GRP_W-1:0] sel_q;
    logic             lsb_fall;

    assign rt = route_line(ev_valid, ev_line);

    isa_irq_bank #(.FOLD_EN(1'b0)) u_sec (
        .clk(clk), .rst(rst),
        .ev_hit(rt.to_sec), .ev_set(ev_set), .ev_idx(rt.idx),
        .fold_in(1'b0),
        .mask_we(sec_mask_we), .mask_wd(mask_wdata),
        .req_q(sec_req_q), .pend_q(sec_pend_q), .pend_nxt(sec_pend_nxt)
    );

    isa_irq_bank #(.FOLD_EN(1'b1)) u_pri (
        .clk(clk), .rst(rst),
        .ev_hit(rt.to_pri), .ev_set(ev_set), .ev_idx(rt.idx),
        .fold_in(|sec_pend_nxt),
        .mask_we(pri_mask_we), .mask_wd(mask_wdata),
        .req_q(pri_req_q), .pend_q(pri_pend_q), .pend_nxt(pri_pend_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= SEL_INIT;
        else if (sel_we) sel_q <= sel_wdata;
    end

    isa_irq_split u_split (
        .clk(clk), .rst(rst),
        .pend_q(pri_pend_q), .pend_nxt(pri_pend_nxt), .sel_q(sel_q),
        .irq_local(irq_local), .irq_isa(irq_isa)
    );

    // Bit 0 is never folded, so only a clearing event on line 0 can drop it.
    assign lsb_fall = pri_req_q[0] && rt.to_pri && !ev_set && (rt.idx == '0);

    isa_irq_tmr_cnt #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst),
        .tick(tmr_tick), .fall(lsb_fall), .cnt(tmr_pending)
    );

    // R3: primary bit 2 tracks the secondary group's pending state.
    assert_fold_R3: assert property (@(posedge clk) disable iff (rst)
        pri_req_q[FOLD_BIT] == (|sec_pend_q));
    // R6: reset values.
    assert_reset_state_R6: assert property (@(posedge clk)
        $past(rst) |-> (sel_q == SEL_INIT && !irq_local && !irq_isa && tmr_pending == '0));
    // R8: lines 16..31 touch no request bit.
    assert_high_line_R8: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_line[LINE_W-1] && !pri_mask_we && !sec_mask_we)
        |=> ($stable(sec_req_q) && $stable(pri_req_q)));
endmodule

// File: tb/tb_isa_irq_router.sv
module tb_isa_irq_router;
    localparam logic [2:0] OP_SET  = 3'd0;
    localparam logic [2:0] OP_CLR  = 3'd1;
    localparam logic [2:0] OP_MSKP = 3'd2;
    localparam logic [2:0] OP_MSKS = 3'd3;
    localparam logic [2:0] OP_SEL  = 3'd4;
    localparam logic [2:0] OP_TICK = 3'd5;
    localparam int NV = 32;

    // {req[24:21], op[20:18], arg[17:10], local[9], isa[8], count[7:0]}
    localparam logic [24:0] VEC [0:NV-1] = '{
        {4'd4, OP_SET,  8'd3,  1'b1, 1'b0, 8'd0},   // R4 line 3 is local
        {4'd4, OP_SET,  8'd5,  1'b1, 1'b1, 8'd0},   // R4 both
        {4'd1, OP_CLR,  8'd3,  1'b0, 1'b1, 8'd0},   // R1
        {4'd1, OP_CLR,  8'd5,  1'b0, 1'b0, 8'd0},   // R1
        {4'd3, OP_SET,  8'd10, 1'b0, 1'b1, 8'd0},   // R3 fold up
        {4'd9, OP_MSKS, 8'h04, 1'b0, 1'b0, 8'd0},   // R9 secondary masked
        {4'd9, OP_MSKS, 8'h00, 1'b0, 1'b1, 8'd0},   // R9 unmasked
        {4'd3, OP_SET,  8'd2,  1'b0, 1'b1, 8'd0},   // R3
        {4'd3, OP_CLR,  8'd2,  1'b0, 1'b1, 8'd0},   // R3 line 2 cannot clear
        {4'd3, OP_CLR,  8'd10, 1'b0, 1'b0, 8'd0},   // R3 fold down
        {4'd3, OP_SET,  8'd2,  1'b0, 1'b0, 8'd0},   // R3 line 2 cannot set
        {4'd2, OP_MSKP, 8'h10, 1'b0, 1'b0, 8'd0},   // R2
        {4'd2, OP_SET,  8'd4,  1'b0, 1'b0, 8'd0},   // R2 masked
        {4'd9, OP_MSKP, 8'h00, 1'b1, 1'b0, 8'd0},   // R9 R2 unmask
        {4'd5, OP_SEL,  8'h00, 1'b1, 1'b0, 8'd0},   // R5 stale
        {4'd8, OP_SET,  8'd16, 1'b1, 1'b0, 8'd0},   // R8 re-evaluate
        {4'd5, OP_SET,  8'd6,  1'b0, 1'b1, 8'd0},   // R5 new selection
        {4'd8, OP_CLR,  8'd22, 1'b0, 1'b1, 8'd0},   // R8 line 22 not 6
        {4'd1, OP_CLR,  8'd4,  1'b0, 1'b1, 8'd0},   // R1
        {4'd1, OP_CLR,  8'd6,  1'b0, 1'b0, 8'd0},   // R1
        {4'd5, OP_SEL,  8'h18, 1'b0, 1'b0, 8'd0},   // R5
        {4'd7, OP_TICK, 8'd0,  1'b0, 1'b0, 8'd1},   // R7
        {4'd7, OP_TICK, 8'd0,  1'b0, 1'b0, 8'd2},   // R7
        {4'd4, OP_SET,  8'd0,  1'b0, 1'b1, 8'd2},   // R4
        {4'd7, OP_CLR,  8'd0,  1'b0, 1'b0, 8'd1},   // R7 fall
        {4'd7, OP_CLR,  8'd0,  1'b0, 1'b0, 8'd1},   // R7 no fall
        {4'd1, OP_SET,  8'd8,  1'b0, 1'b1, 8'd1},   // R1 secondary bit 0
        {4'd1, OP_CLR,  8'd8,  1'b0, 1'b0, 8'd1},   // R1 no timer effect
        {4'd7, OP_SET,  8'd0,  1'b0, 1'b1, 8'd1},   // R7
        {4'd7, OP_CLR,  8'd0,  1'b0, 1'b0, 8'd0},   // R7
        {4'd7, OP_SET,  8'd0,  1'b0, 1'b1, 8'd0},   // R7
        {4'd7, OP_CLR,  8'd0,  1'b0, 1'b0, 8'd0}    // R7 floor
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ev_valid = 1'b0, ev_set = 1'b0;
    logic [4:0] ev_line = '0;
    logic       pri_mask_we = 1'b0, sec_mask_we = 1'b0, sel_we = 1'b0, tmr_tick = 1'b0;
    logic [7:0] mask_wdata = '0, sel_wdata = '0;
    logic       irq_local, irq_isa;
    logic [7:0] tmr_pending;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    isa_irq_router dut (
        .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_line(ev_line), .ev_set(ev_set),
        .pri_mask_we(pri_mask_we), .sec_mask_we(sec_mask_we), .mask_wdata(mask_wdata),
        .sel_we(sel_we), .sel_wdata(sel_wdata), .tmr_tick(tmr_tick),
        .irq_local(irq_local), .irq_isa(irq_isa), .tmr_pending(tmr_pending)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic l, input logic i, input logic [7:0] c);
        check({tag, " irq_local"}, {7'd0, irq_local}, {7'd0, l});
        check({tag, " irq_isa"}, {7'd0, irq_isa}, {7'd0, i});
        check({tag, " tmr_pending"}, tmr_pending, c);
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic step(input logic [2:0] op, input logic [7:0] arg, input logic tick_too);
        case (op)
            OP_SET:  begin ev_valid = 1'b1; ev_set = 1'b1; ev_line = arg[4:0]; end
            OP_CLR:  begin ev_valid = 1'b1; ev_set = 1'b0; ev_line = arg[4:0]; end
            OP_MSKP: begin pri_mask_we = 1'b1; mask_wdata = arg; end
            OP_MSKS: begin sec_mask_we = 1'b1; mask_wdata = arg; end
            OP_SEL:  begin sel_we = 1'b1; sel_wdata = arg; end
            default: tmr_tick = 1'b1;
        endcase
        if (tick_too) tmr_tick = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0; pri_mask_we = 1'b0; sec_mask_we = 1'b0;
        sel_we = 1'b0; tmr_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R6 reset", 1'b0, 1'b0, 8'd0);

        for (int k = 0; k < NV; k++) begin
            logic [24:0] v;
            v = VEC[k];
            step(v[20:18], v[17:10], 1'b0);
            check_all($sformatf("R%0d vec %0d", v[24:21], k), v[9], v[8], v[7:0]);
        end

        // R7: a tick and a fall in one cycle cancel.
        step(OP_TICK, 8'd0, 1'b0);
        step(OP_SET, 8'd0, 1'b0);
        check_all("R7 before joint", 1'b0, 1'b1, 8'd1);
        step(OP_CLR, 8'd0, 1'b1);
        check_all("R7 tick with fall", 1'b0, 1'b0, 8'd1);

        // R7: saturation at the top of the count.
        for (int k = 0; k < 300; k++) step(OP_TICK, 8'd0, 1'b0);
        check("R7 saturate", tmr_pending, 8'd255);

        // R6: reset in mid-run restores the default selection.
        step(OP_SEL, 8'h00, 1'b0);
        step(OP_SET, 8'd7, 1'b0);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_all("R6 mid-run reset", 1'b0, 1'b0, 8'd0);
        step(OP_SET, 8'd3, 1'b0);
        check_all("R6 default selection line 3", 1'b1, 1'b0, 8'd0);
        step(OP_SET, 8'd1, 1'b0);
        check_all("R6 default selection line 1", 1'b1, 1'b1, 8'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule